// File: doc/BRIEF.md
# Stack Pointer and Status Byte Unit

This unit belongs to an 8-bit accumulator processor. It owns two pieces of state: the stack pointer and the processor status byte. It runs every stack transfer the instruction sequencer asks for:
- pushing a byte,
- popping a byte,
- popping a 16-bit address,
- pushing and pulling the status byte,
- the three-pop return-from-interrupt sequence.

The stack sits in a fixed memory page, so each stack access uses address `{page, sp}`. The unit reaches memory through a simple synchronous port. Read data arrives one cycle after the read strobe.

A command is offered with `cmd_valid` and `cmd_op`. It is taken only while `cmd_ready` is high, which is the case only in the idle state. `done` pulses for one cycle when the command has finished. In that same cycle `pop_byte`, `pop_word`, `sp_out` and `status_out` show the results.

The sequencer has six states:
- **IDLE**: waits for a command.
- **PUSH**: writes the stack slot and decrements the pointer.
- **INC**: pre-increments the pointer before a read.
- **READ**: issues the read.
- **CAPT**: captures the returned byte into the status register, the low or high half of the word result, or the byte result.
- **DONE**: drives the completion strobe.

The state transitions are:
- IDLE goes to PUSH for the two push commands, and to INC for the four pop commands.
- PUSH goes to DONE.
- INC goes to READ, and READ goes to CAPT.
- CAPT returns to INC when another byte of the same command remains (status then low then high for return-from-interrupt; low then high for a word pop). Otherwise CAPT goes to DONE.
- DONE goes back to IDLE.

Top module: `cpu_stack_unit`

## Requirements
- R1: After reset the stack pointer is 0xFD, the status byte is 0x24, `cmd_ready` is 1, `done` is 0, and no memory access is made.
- R2: Command code 0 (push byte) writes `cmd_data` to address 0x0100+SP with a single write strobe. SP then decrements with 8-bit wrap, so a push at SP=0x00 writes 0x0100 and leaves SP=0xFF.
- R3: Command code 1 (pop byte) first increments SP with 8-bit wrap and then reads 0x0100+SP. The byte read appears on `pop_byte`. A pop at SP=0xFF reads 0x0100 and leaves SP=0x00.
- R4: Command code 3 (push status) writes the status byte with bit 4 and bit 5 both set to 1 to the stack. The status register itself is not changed.
- R5: Command code 4 (pull status) pops a byte into the status register with bit 4 forced to 0 and bit 5 forced to 1.
- R6: Command code 2 (pop word) pops two bytes. The first is the low byte and the second the high byte of `pop_word`. SP advances by 2.
- R7: Command code 5 (return from interrupt) pops the status byte under the R5 rule, then pops a low byte and then a high byte into `pop_word`. SP advances by 3.
- R8: `done` is high for exactly one cycle per accepted command. `cmd_ready` is high only when idle. A command offered while busy is dropped and causes no memory access.
- R9: Command codes 6 and 7 are ignored. They cause no memory access, no `done` pulse, and no change to SP or status.
- R10: Every memory access uses 0x01 as the high address byte. A write and a read never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 pop word, 3 push status, 4 pull status, 5 return from interrupt) |
| cmd_data | input | 8 | Byte for a push command |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| done | output | 1 | One-cycle completion strobe |
| pop_byte | output | 8 | Result of the last byte pop |
| pop_word | output | 16 | Result of the last word pop or return from interrupt |
| sp_out | output | 8 | Current stack pointer |
| status_out | output | 8 | Current status byte |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_rdata | input | 8 | Memory read data |

## Verification
A stack pointer that is off by one shows up at once: the very next access lands on the wrong byte of page 0x01, and `sp_out` disagrees with the model when `done` pulses. A wrong capture slot or a missing bit-4/bit-5 fix-up is visible on `pop_word` or `status_out` in the `done` cycle of that same command. A sequencer stuck in a busy state holds `cmd_ready` low and never pulses `done`, so the next command stalls.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Command codes at the port
    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_POPW  = 3'd2,
        OP_PUSHP = 3'd3,
        OP_PULLP = 3'd4,
        OP_RETI  = 3'd5
    } stk_op_e;

    localparam logic [2:0] OP_LAST = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH,
        S_INC,
        S_READ,
        S_CAPT,
        S_DONE
    } stk_state_e;

    // Destination of the byte returned by a read
    typedef enum logic [1:0] {
        SL_BYTE,
        SL_STAT,
        SL_LO,
        SL_HI
    } stk_slot_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = 8'hFD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= RST_VAL;
        end else if (inc) begin
            sp <= sp + 1'b1;
        end else if (dec) begin
            sp <= sp - 1'b1;
        end
    end

endmodule

// File: rtl/stk_status.sv
module stk_status #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = 8'h24,
    parameter int           BRK_BIT = 4,
    parameter int           ONE_BIT = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] stat_q,
    output logic [W-1:0] push_val
);

    localparam logic [W-1:0] BRK_MASK = {{(W-1){1'b0}}, 1'b1} << BRK_BIT;
    localparam logic [W-1:0] ONE_MASK = {{(W-1){1'b0}}, 1'b1} << ONE_BIT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RST_VAL;
        end else if (load_en) begin
            stat_q <= (load_val & ~BRK_MASK) | ONE_MASK;
        end
    end

    assign push_val = stat_q | BRK_MASK | ONE_MASK;

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(stat_q)); // R4

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       ready,
    output logic       accept,
    output logic       done,
    output logic       sp_inc,
    output logic       sp_dec,
    output logic       mem_we,
    output logic       mem_re,
    output logic       wr_status,
    output logic       st_load,
    output logic       cap_byte,
    output logic       cap_lo,
    output logic       cap_hi
);

    stk_state_e state_q, state_n;
    stk_op_e    op_q, op_n;
    stk_slot_e  slot_q, slot_n;
    logic       legal;

    assign legal  = (cmd_op <= OP_LAST);
    assign accept = (state_q == S_IDLE) && cmd_valid && legal;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PUSH;
            slot_q  <= SL_BYTE;
        end else begin
            state_q <= state_n;
            op_q    <= op_n;
            slot_q  <= slot_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        op_n    = op_q;
        slot_n  = slot_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    op_n = stk_op_e'(cmd_op);
                    if (cmd_op == OP_PUSH || cmd_op == OP_PUSHP) begin
                        state_n = S_PUSH;
                    end else begin
                        state_n = S_INC;
                        if (cmd_op == OP_POP)       slot_n = SL_BYTE;
                        else if (cmd_op == OP_POPW) slot_n = SL_LO;
                        else                        slot_n = SL_STAT;
                    end
                end
            end
            S_PUSH: state_n = S_DONE;
            S_INC:  state_n = S_READ;
            S_READ: state_n = S_CAPT;
            S_CAPT: begin
                if (slot_q == SL_STAT && op_q == OP_RETI) begin
                    slot_n  = SL_LO;
                    state_n = S_INC;
                end else if (slot_q == SL_LO) begin
                    slot_n  = SL_HI;
                    state_n = S_INC;
                end else begin
                    state_n = S_DONE;
                end
            end
            S_DONE: state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ready     = 1'b0;
        done      = 1'b0;
        sp_inc    = 1'b0;
        sp_dec    = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        wr_status = 1'b0;
        st_load   = 1'b0;
        cap_byte  = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        unique case (state_q)
            S_IDLE: ready = 1'b1;
            S_PUSH: begin
                mem_we    = 1'b1;
                sp_dec    = 1'b1;
                wr_status = (op_q == OP_PUSHP);
            end
            S_INC:  sp_inc = 1'b1;
            S_READ: mem_re = 1'b1;
            S_CAPT: begin
                st_load  = (slot_q == SL_STAT);
                cap_byte = (slot_q == SL_BYTE);
                cap_lo   = (slot_q == SL_LO);
                cap_hi   = (slot_q == SL_HI);
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready); // R8

endmodule

// File: rtl/cpu_stack_unit.sv
module cpu_stack_unit #(
    parameter int                          DATA_W  = 8,
    parameter int                          ADDR_W  = 16,
    parameter logic [ADDR_W-DATA_W-1:0]    PAGE    = 8'h01,
    parameter logic [DATA_W-1:0]           SP_INIT = 8'hFD,
    parameter logic [DATA_W-1:0]           ST_INIT = 8'h24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [DATA_W-1:0]   cmd_data,
    output logic                cmd_ready,
    output logic                done,
    output logic [DATA_W-1:0]   pop_byte,
    output logic [2*DATA_W-1:0] pop_word,
    output logic [DATA_W-1:0]   sp_out,
    output logic [DATA_W-1:0]   status_out,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    input  logic [DATA_W-1:0]   mem_rdata
);

    localparam int WORD_W = 2 * DATA_W;

    logic              accept, sp_inc, sp_dec, wr_status;
    logic              st_load, cap_byte, cap_lo, cap_hi;
    logic [DATA_W-1:0] sp_q, stat_q, stat_push, data_q, byte_q;
    logic [WORD_W-1:0] word_q;

    stk_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .ready     (cmd_ready),
        .accept    (accept),
        .done      (done),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .wr_status (wr_status),
        .st_load   (st_load),
        .cap_byte  (cap_byte),
        .cap_lo    (cap_lo),
        .cap_hi    (cap_hi)
    );

    stk_ptr #(.W(DATA_W), .RST_VAL(SP_INIT)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp_q)
    );

    stk_status #(.W(DATA_W), .RST_VAL(ST_INIT), .BRK_BIT(4), .ONE_BIT(5)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (st_load),
        .load_val (mem_rdata),
        .stat_q   (stat_q),
        .push_val (stat_push)
    );

    // Operand latch and pop results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            byte_q <= '0;
            word_q <= '0;
        end else begin
            if (accept)   data_q <= cmd_data;
            if (cap_byte) byte_q <= mem_rdata;
            if (cap_lo)   word_q[DATA_W-1:0] <= mem_rdata;
            if (cap_hi)   word_q[WORD_W-1:DATA_W] <= mem_rdata;
        end
    end

    assign mem_addr   = {PAGE, sp_q};
    assign mem_wdata  = wr_status ? stat_push : data_q;
    assign pop_byte   = byte_q;
    assign pop_word   = word_q;
    assign sp_out     = sp_q;
    assign status_out = stat_q;

    AST_PUSH_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_q == $past(sp_q) - 1'b1); // R2
    AST_INC_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> sp_q == $past(sp_q) + 1'b1); // R3
    AST_PULL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        st_load |=> status_out[5] && !status_out[4]); // R5
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re})); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !mem_we && !mem_re && !done); // R8

endmodule

// File: tb/cpu_stack_unit_bench.sv
module cpu_stack_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_data;
    logic        cmd_ready, done, mem_we, mem_re;
    logic [7:0]  pop_byte, sp_out, status_out, mem_wdata;
    logic [7:0]  mem_rdata;
    logic [15:0] pop_word, mem_addr;

    always #5 clk = ~clk;

    cpu_stack_unit u_cpu_stack_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_data   (cmd_data),
        .cmd_ready  (cmd_ready),
        .done       (done),
        .pop_byte   (pop_byte),
        .pop_word   (pop_word),
        .sp_out     (sp_out),
        .status_out (status_out),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_re     (mem_re),
        .mem_rdata  (mem_rdata)
    );

    typedef struct {
        logic [2:0]  op;
        logic [7:0]  sp;
        logic [7:0]  st;
        logic [15:0] val;
        logic [7:0]  widx;
        logic [7:0]  wval;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    int         done_cnt = 0;
    int         issued = 0;
    int         we_cnt = 0;
    int         re_cnt = 0;
    logic       prev_done = 1'b0;
    logic [7:0] ram [256];
    logic [7:0] mdl [256];
    logic [7:0] m_sp;
    logic [7:0] m_st;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R6";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R7";
        endcase
    endfunction

    // Stack page memory with one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= 8'(i) ^ 8'h5A;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    // Access monitor (R10)
    always @(negedge clk) begin
        if (rst_n && (mem_we || mem_re)) begin
            if (mem_we) we_cnt++;
            if (mem_re) re_cnt++;
            chk("R10 page", {8'h00, mem_addr[15:8]}, 16'h0001);
            chk("R10 exclusive", {15'd0, mem_we && mem_re}, 16'd0);
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            done_cnt++;
            chk("R8 single pulse", {15'd0, prev_done}, 16'd0);
            if (sb.size() == 0) begin
                chk("R8 unexpected done", 16'd1, 16'd0);
            end else begin
                e = sb.pop_front();
                chk({tag(e.op), " sp"}, {8'h00, sp_out}, {8'h00, e.sp});
                chk({tag(e.op), " status"}, {8'h00, status_out}, {8'h00, e.st});
                case (e.op)
                    3'd0, 3'd3: chk({tag(e.op), " stack byte"}, {8'h00, ram[e.widx]}, {8'h00, e.wval});
                    3'd1:       chk({tag(e.op), " pop byte"}, {8'h00, pop_byte}, e.val);
                    3'd2, 3'd5: chk({tag(e.op), " pop word"}, pop_word, e.val);
                    default: ;
                endcase
            end
        end
        prev_done = rst_n && done;
    end

    // Driver: model the command, queue the expectation, drive the port
    task automatic issue(input logic [2:0] op, input logic [7:0] d, input bit intrude);
        exp_t e;
        logic [7:0] lo, hi;
        e.op = op; e.val = '0; e.widx = '0; e.wval = '0;
        case (op)
            3'd0: begin e.widx = m_sp; e.wval = d; mdl[m_sp] = d; m_sp = m_sp - 1'b1; end
            3'd3: begin e.widx = m_sp; e.wval = m_st | 8'h30; mdl[m_sp] = e.wval; m_sp = m_sp - 1'b1; end
            3'd1: begin m_sp = m_sp + 1'b1; e.val = {8'h00, mdl[m_sp]}; end
            3'd2: begin
                m_sp = m_sp + 1'b1; lo = mdl[m_sp];
                m_sp = m_sp + 1'b1; hi = mdl[m_sp];
                e.val = {hi, lo};
            end
            3'd4: begin m_sp = m_sp + 1'b1; m_st = (mdl[m_sp] & 8'hEF) | 8'h20; end
            default: begin
                m_sp = m_sp + 1'b1; m_st = (mdl[m_sp] & 8'hEF) | 8'h20;
                m_sp = m_sp + 1'b1; lo = mdl[m_sp];
                m_sp = m_sp + 1'b1; hi = mdl[m_sp];
                e.val = {hi, lo};
            end
        endcase
        e.sp = m_sp; e.st = m_st;
        sb.push_back(e);
        issued++;
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(negedge clk);
        if (intrude) begin
            cmd_op = 3'd0; cmd_data = 8'hEE;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
    endtask

    initial begin
        int we0, re0, dn0;
        bit ready_drop;
        for (int i = 0; i < 256; i++) mdl[i] = 8'(i) ^ 8'h5A;
        m_sp = 8'hFD; m_st = 8'h24;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sp", {8'h00, sp_out}, 16'h00FD);
        chk("R1 status", {8'h00, status_out}, 16'h0024);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {15'd0, cmd_ready}, 16'd1);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 no access", {14'd0, mem_we, mem_re}, 16'd0);

        issue(3'd0, 8'hA7, 0);               // R2
        issue(3'd0, 8'h3C, 0);               // R2
        issue(3'd3, 8'h00, 0);               // R4: writes 0x34
        issue(3'd1, 8'h00, 0);               // R3
        issue(3'd4, 8'h00, 0);               // R5: 0x3C -> 0x2C
        issue(3'd0, 8'hC0, 0);
        issue(3'd0, 8'h05, 0);
        issue(3'd0, 8'hDF, 0);
        issue(3'd5, 8'h00, 0);               // R7: status 0xEF, word 0xC005
        issue(3'd0, 8'h9A, 0);
        issue(3'd0, 8'h78, 0);
        issue(3'd2, 8'h00, 0);               // R6: word 0x9A78

        // R8: a push offered while busy with a pop is dropped
        we0 = we_cnt;
        issue(3'd1, 8'h00, 1);
        repeat (3) @(negedge clk);
        chk("R8 busy push dropped (writes)", 16'(we_cnt - we0), 16'd0);
        chk("R8 busy push dropped (sp)", {8'h00, sp_out}, {8'h00, m_sp});

        // R9: codes 6 and 7 are ignored
        we0 = we_cnt; re0 = re_cnt; dn0 = done_cnt; ready_drop = 0;
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 8'h11;
        repeat (3) begin @(negedge clk); if (!cmd_ready) ready_drop = 1; end
        cmd_op = 3'd7;
        repeat (3) begin @(negedge clk); if (!cmd_ready) ready_drop = 1; end
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 stays idle", {15'd0, ready_drop}, 16'd0);
        chk("R9 no access", 16'((we_cnt - we0) + (re_cnt - re0)), 16'd0);
        chk("R9 no done", 16'(done_cnt - dn0), 16'd0);
        chk("R9 sp kept", {8'h00, sp_out}, {8'h00, m_sp});
        chk("R9 status kept", {8'h00, status_out}, {8'h00, m_st});

        // R3 wrap: pop up to SP=0xFF, then pop across to 0x00
        while (m_sp != 8'hFF) issue(3'd1, 8'h00, 0);
        issue(3'd1, 8'h00, 0);
        chk("R3 wrap sp", {8'h00, sp_out}, 16'h0000);
        // R2 wrap: push at SP=0x00
        issue(3'd0, 8'h66, 0);
        chk("R2 wrap slot", {8'h00, ram[0]}, 16'h0066);
        issue(3'd3, 8'h00, 0);               // R4 with status 0xEF

        repeat (3) @(negedge clk);
        chk("R8 done count", 16'(done_cnt), 16'(issued));
        chk("R8 queue drained", 16'(sb.size()), 16'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule